// File: doc/BRIEF.md
# Service Button Action Classifier

This block watches a single active-low service push-button and decides what each press means. The idle level of the button is high through an external pull-up. The raw level goes through a synchronizer and a debounce filter. Each clean press is then timed in millisecond ticks and classified into one of three actions:

- A brief press lights a status indicator for a fixed display period.
- A long hold during normal operation asks for a reboot.
- A long hold that was already under way before power-up finished asks for a restore to factory defaults.

The indicator also shows the error state. It is green when no error is flagged. When an error is present it shows a colour chosen by the error code, and it stays lit for as long as the error lasts.

The block is driven by a one-cycle millisecond tick. It also reads a power-up-done flag, an error-present flag and an error code. Its outputs feed other logic, which runs the indicator's serial protocol, performs the reboot and erases the configuration store.

Top module: `svc_button_classifier`

## Requirements
- R1: The button input passes through a two-flop synchronizer, and a level change is accepted only after it persists for DEBOUNCE_MS consecutive ticks; a shorter glitch causes no action.
- R2: A press that begins with powerUpDone high and is released after fewer than SHORT_MS ticks drives indOn high for SHOW_MS ticks, then low again.
- R3: With errPresent low and the display running, indColour is 0 (green).
- R4: When errPresent is high, indOn is high and indColour equals {1'b1, errCode}, whether or not the display runs.
- R5: With errPresent low and no display running, indOn is low and indColour is 0.
- R6: A press that begins with powerUpDone high and is held for HOLD_MS ticks raises rebootReq for exactly one clock cycle. Further holding does not raise it again, and the later release does not light the indicator.
- R7: A press whose debounced start comes while powerUpDone is low, and which is held for HOLD_MS ticks, raises factoryReq for one cycle instead of rebootReq. Neither request is ever raised while powerUpDone is low.
- R8: A press released after at least SHORT_MS ticks but before HOLD_MS ticks causes no action.
- R9: A brief press made while the display is running restarts the full SHOW_MS period.
- R10: After reset, indOn (with errPresent low), rebootReq and factoryReq are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| msTick | input | 1 | One-cycle strobe, once per millisecond |
| powerUpDone | input | 1 | High once system power-up has completed |
| errPresent | input | 1 | An error is currently flagged |
| errCode | input | ERR_W | Code of the current error |
| buttonN | input | 1 | Raw button level, low while pressed |
| indOn | output | 1 | Status indicator on |
| indColour | output | ERR_W+1 | Indicator colour: 0 is green, {1, code} is an error colour |
| rebootReq | output | 1 | One-cycle reboot request |
| factoryReq | output | 1 | One-cycle factory-default restore request |

## Verification
The hardest case to reach is the factory-restore path. It needs the button to be seen as pressed before power-up completes and to stay held across the rise of powerUpDone. The bench gets there by asserting reset with the button already low and powerUpDone low. It lets the debounce settle, raises powerUpDone partway through the hold, and then checks that only factoryReq pulses. The short-versus-ignored boundary is approached by sweeping hold lengths around SHORT_MS in a small tick configuration.

// File: rtl/svc_btn_pkg.sv
package svc_btn_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic clrDur;
    logic runDur;
    logic loadShow;
  } dpCmd_t;

  // Status from datapath to control
  typedef struct packed {
    logic pressEdge;
    logic releaseEdge;
    logic durShort;
    logic durHold;
    logic showing;
  } dpStat_t;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_PRESSED = 2'd1,
    ST_LATCHED = 2'd2
  } ctlState_t;

endpackage

// File: rtl/svc_btn_debounce.sv
module svc_btn_debounce #(
  parameter int SYNC_STAGES = 2,
  parameter int DEBOUNCE_MS = 20
) (
  input  logic clk,
  input  logic rstN,
  input  logic msTick,
  input  logic buttonN,
  output logic pressEdge,
  output logic releaseEdge
);
  localparam int DB_W = $clog2(DEBOUNCE_MS + 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic [DB_W-1:0]        dbCnt;
  logic                   stable;     // 1 = pressed
  logic                   pressedLvl;

  assign pressedLvl = ~syncQ[SYNC_STAGES-1];

  // R1: synchronizer chain, idle high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], buttonN};
  end

  // R1: debounce filter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dbCnt       <= '0;
      stable      <= 1'b0;
      pressEdge   <= 1'b0;
      releaseEdge <= 1'b0;
    end else begin
      pressEdge   <= 1'b0;
      releaseEdge <= 1'b0;
      if (pressedLvl == stable) begin
        dbCnt <= '0;
      end else if (msTick) begin
        if (dbCnt == DB_W'(DEBOUNCE_MS - 1)) begin
          dbCnt       <= '0;
          stable      <= pressedLvl;
          pressEdge   <= pressedLvl;
          releaseEdge <= ~pressedLvl;
        end else begin
          dbCnt <= dbCnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/svc_btn_datapath.sv
module svc_btn_datapath
  import svc_btn_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DEBOUNCE_MS = 20,
  parameter int SHORT_MS    = 1000,
  parameter int HOLD_MS     = 5000,
  parameter int SHOW_MS     = 10000,
  parameter int ERR_W       = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             msTick,
  input  logic             buttonN,
  input  logic             errPresent,
  input  logic [ERR_W-1:0] errCode,
  input  dpCmd_t           cmd,
  output dpStat_t          stat,
  output logic             indOn,
  output logic [ERR_W:0]   indColour
);
  localparam int DUR_W  = $clog2(HOLD_MS + 1);
  localparam int SHOW_W = $clog2(SHOW_MS + 1);

  logic [DUR_W-1:0]  durCnt;
  logic [SHOW_W-1:0] showCnt;
  logic              pressEdge, releaseEdge;

  svc_btn_debounce #(
    .SYNC_STAGES(SYNC_STAGES),
    .DEBOUNCE_MS(DEBOUNCE_MS)
  ) uDeb (
    .clk        (clk),
    .rstN       (rstN),
    .msTick     (msTick),
    .buttonN    (buttonN),
    .pressEdge  (pressEdge),
    .releaseEdge(releaseEdge)
  );

  // Press duration in ticks, saturating at the hold mark
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                          durCnt <= '0;
    else if (cmd.clrDur)                                durCnt <= '0;
    else if (cmd.runDur && msTick && durCnt != DUR_W'(HOLD_MS)) durCnt <= durCnt + 1'b1;
  end

  // Display timer; a reload restarts the full period (R9)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       showCnt <= '0;
    else if (cmd.loadShow)           showCnt <= SHOW_W'(SHOW_MS);
    else if (msTick && showCnt != 0) showCnt <= showCnt - 1'b1;
  end

  assign stat.pressEdge   = pressEdge;
  assign stat.releaseEdge = releaseEdge;
  assign stat.durShort    = durCnt < DUR_W'(SHORT_MS);
  assign stat.durHold     = durCnt >= DUR_W'(HOLD_MS);
  assign stat.showing     = showCnt != 0;

  // R3, R4, R5: indicator and colour selection
  assign indOn     = stat.showing | errPresent;
  assign indColour = errPresent ? {1'b1, errCode} : '0;
endmodule

// File: rtl/svc_btn_control.sv
module svc_btn_control
  import svc_btn_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    powerUpDone,
  input  dpStat_t stat,
  output dpCmd_t  cmd,
  output logic    rebootReq,
  output logic    factoryReq
);
  ctlState_t st, stNxt;
  logic      bootHeld, bootNxt;
  logic      fireReboot, fireFactory;

  always_comb begin
    stNxt       = st;
    bootNxt     = bootHeld;
    cmd         = '0;
    fireReboot  = 1'b0;
    fireFactory = 1'b0;
    case (st)
      ST_IDLE: begin
        if (stat.pressEdge) begin
          cmd.clrDur = 1'b1;
          bootNxt    = ~powerUpDone;     // R7: press started before power-up
          stNxt      = ST_PRESSED;
        end
      end
      ST_PRESSED: begin
        cmd.runDur = 1'b1;
        if (stat.releaseEdge) begin
          // R2: brief press; R8: mid-length release does nothing
          if (stat.durShort && !bootHeld && powerUpDone) cmd.loadShow = 1'b1;
          stNxt = ST_IDLE;
        end else if (stat.durHold && powerUpDone) begin
          fireFactory = bootHeld;        // R7
          fireReboot  = ~bootHeld;       // R6
          stNxt       = ST_LATCHED;
        end
      end
      ST_LATCHED: begin
        if (stat.releaseEdge) stNxt = ST_IDLE;   // R6: release ignored
      end
      default: stNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st         <= ST_IDLE;
      bootHeld   <= 1'b0;
      rebootReq  <= 1'b0;
      factoryReq <= 1'b0;
    end else begin
      st         <= stNxt;
      bootHeld   <= bootNxt;
      rebootReq  <= fireReboot;
      factoryReq <= fireFactory;
    end
  end
endmodule

// File: rtl/svc_button_classifier.sv
module svc_button_classifier
  import svc_btn_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DEBOUNCE_MS = 20,
  parameter int SHORT_MS    = 1000,
  parameter int HOLD_MS     = 5000,
  parameter int SHOW_MS     = 10000,
  parameter int ERR_W       = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             msTick,
  input  logic             powerUpDone,
  input  logic             errPresent,
  input  logic [ERR_W-1:0] errCode,
  input  logic             buttonN,
  output logic             indOn,
  output logic [ERR_W:0]   indColour,
  output logic             rebootReq,
  output logic             factoryReq
);
  dpCmd_t  cmd;
  dpStat_t stat;

  svc_btn_datapath #(
    .SYNC_STAGES(SYNC_STAGES), .DEBOUNCE_MS(DEBOUNCE_MS), .SHORT_MS(SHORT_MS),
    .HOLD_MS(HOLD_MS), .SHOW_MS(SHOW_MS), .ERR_W(ERR_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .msTick(msTick), .buttonN(buttonN),
    .errPresent(errPresent), .errCode(errCode), .cmd(cmd), .stat(stat),
    .indOn(indOn), .indColour(indColour)
  );

  svc_btn_control uCtl (
    .clk(clk), .rstN(rstN), .powerUpDone(powerUpDone), .stat(stat),
    .cmd(cmd), .rebootReq(rebootReq), .factoryReq(factoryReq)
  );
endmodule

// File: rtl/svc_button_classifier_chk.sv
module svc_button_classifier_chk #(
  parameter int ERR_W = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             powerUpDone,
  input logic             errPresent,
  input logic [ERR_W-1:0] errCode,
  input logic             indOn,
  input logic [ERR_W:0]   indColour,
  input logic             rebootReq,
  input logic             factoryReq
);
  // R6: reboot request lasts one cycle
  a_r6_reboot_single: assert property (@(posedge clk) disable iff (!rstN)
    rebootReq |=> !rebootReq);

  // R7: factory request lasts one cycle
  a_r7_factory_single: assert property (@(posedge clk) disable iff (!rstN)
    factoryReq |=> !factoryReq);

  // R6/R7: never both requests together
  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(rebootReq && factoryReq));

  // R7: requests only after power-up completed
  a_r7_needs_power: assert property (@(posedge clk) disable iff (!rstN)
    (rebootReq || factoryReq) |-> $past(powerUpDone));

  // R4: error keeps the indicator lit with its error colour
  a_r4_error_lit: assert property (@(posedge clk) disable iff (!rstN)
    errPresent |-> (indOn && indColour == {1'b1, errCode}));

  // R3/R5: without an error the colour is green
  a_r3_green: assert property (@(posedge clk) disable iff (!rstN)
    !errPresent |-> indColour == '0);
endmodule

bind svc_button_classifier svc_button_classifier_chk #(.ERR_W(ERR_W)) uChk (
  .clk(clk), .rstN(rstN), .powerUpDone(powerUpDone), .errPresent(errPresent),
  .errCode(errCode), .indOn(indOn), .indColour(indColour),
  .rebootReq(rebootReq), .factoryReq(factoryReq)
);

// File: tb/svc_button_classifier_test.sv
module svc_button_classifier_test;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int DEB        = 3;
  localparam int SHORT      = 10;
  localparam int HOLD       = 30;
  localparam int SHOW       = 40;
  localparam int EW         = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic msTick = 1'b0;
  logic powerUpDone = 1'b0;
  logic errPresent = 1'b0;
  logic [EW-1:0] errCode = '0;
  logic buttonN = 1'b1;
  logic indOn;
  logic [EW:0] indColour;
  logic rebootReq, factoryReq;

  int nChecks = 0;
  int nFails  = 0;
  int phase   = 0;
  int tickNum = 0;
  int cycles  = 0;
  int rebootCnt = 0, factoryCnt = 0, rebootTick = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  svc_button_classifier #(
    .DEBOUNCE_MS(DEB), .SHORT_MS(SHORT), .HOLD_MS(HOLD), .SHOW_MS(SHOW), .ERR_W(EW)
  ) uut (
    .clk(clk), .rstN(rstN), .msTick(msTick), .powerUpDone(powerUpDone),
    .errPresent(errPresent), .errCode(errCode), .buttonN(buttonN),
    .indOn(indOn), .indColour(indColour), .rebootReq(rebootReq), .factoryReq(factoryReq)
  );

  // Tick generator and pulse monitor, all on the falling edge
  always @(negedge clk) begin
    if (msTick) tickNum <= tickNum + 1;
    phase  <= (phase == TICK_DIV-1) ? 0 : phase + 1;
    msTick <= (phase == TICK_DIV-1);
    if (rebootReq)  begin rebootCnt <= rebootCnt + 1; rebootTick <= tickNum; end
    if (factoryReq) factoryCnt <= factoryCnt + 1;
  end

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic waitTicks(input int n);
    repeat (n * TICK_DIV) @(negedge clk);
  endtask

  task automatic clearCounts();
    rebootCnt = 0; factoryCnt = 0;
  endtask

  // Press for n ticks, release, let the release debounce settle
  task automatic pressFor(input int n);
    buttonN = 1'b0;
    waitTicks(n);
    buttonN = 1'b1;
    waitTicks(DEB + 2);
  endtask

  // Watchdog
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      nChecks++; nFails++;
      $display("FAIL watchdog: actual %0d expected 0", cycles);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int pressTick;
    repeat (5) @(negedge clk);
    // R10: reset state
    check("R10 indOn at reset", int'(indOn), 0);
    check("R10 rebootReq at reset", int'(rebootReq), 0);
    check("R10 factoryReq at reset", int'(factoryReq), 0);

    // R7: button held through power-up
    buttonN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    clearCounts();
    waitTicks(DEB + 5);
    powerUpDone = 1'b1;
    waitTicks(HOLD + 10);
    check("R7 factory pulse count", factoryCnt, 1);
    check("R7 no reboot on boot hold", rebootCnt, 0);
    buttonN = 1'b1;
    waitTicks(DEB + 3);
    check("R7 release after boot hold no display", int'(indOn), 0);
    check("R5 idle colour", int'(indColour), 0);

    // R1: glitch shorter than the filter
    buttonN = 1'b0; repeat (TICK_DIV) @(negedge clk); buttonN = 1'b1;
    waitTicks(DEB + 3);
    check("R1 glitch ignored", int'(indOn), 0);

    // R2/R8: sweep press lengths around the short limit
    for (int n = DEB + 1; n <= HOLD - 5; n += 2) begin
      pressFor(n);
      check($sformatf("R2/R8 len %0d indOn", n), int'(indOn), (n < SHORT - 1) ? 1 : 0);
      if (indOn) check("R3 green while showing", int'(indColour), 0);
      waitTicks(SHOW + 3);
      check($sformatf("R2 len %0d display ended", n), int'(indOn), 0);
    end

    // R2: display duration edges
    pressFor(2 + DEB);
    waitTicks(SHOW - 2*DEB - 6);
    check("R2 still on near end", int'(indOn), 1);
    waitTicks(2*DEB + 10);
    check("R2 off after period", int'(indOn), 0);

    // R9: retrigger restarts the period
    pressFor(DEB + 2);
    waitTicks(20);
    pressFor(DEB + 2);
    waitTicks(25);
    check("R9 retrigger extends display", int'(indOn), 1);
    waitTicks(SHOW);
    check("R9 retriggered display ends", int'(indOn), 0);

    // R6: long hold during normal operation
    clearCounts();
    pressTick = tickNum;
    buttonN = 1'b0;
    waitTicks(HOLD + DEB + 15);
    check("R6 reboot pulse count", rebootCnt, 1);
    check("R6 no factory", factoryCnt, 0);
    check("R6 reboot timing in window",
          int'((rebootTick - pressTick) >= HOLD + DEB - 1 && (rebootTick - pressTick) <= HOLD + DEB + 2), 1);
    buttonN = 1'b1;
    waitTicks(DEB + 3);
    check("R6 release after hold no display", int'(indOn), 0);
    check("R6 no retrigger on release", rebootCnt, 1);

    // R4: error colour sweep, with and without display
    for (int c = 0; c < (1 << EW); c++) begin
      errPresent = 1'b1; errCode = EW'(c);
      @(negedge clk);
      check($sformatf("R4 err %0d indOn", c), int'(indOn), 1);
      check($sformatf("R4 err %0d colour", c), int'(indColour), (1 << EW) | c);
    end
    pressFor(DEB + 2);
    check("R4 colour with display", int'(indColour), (1 << EW) | ((1 << EW) - 1));
    errPresent = 1'b0;
    @(negedge clk);
    check("R3 green after error clears", int'(indColour), 0);
    check("R3 display still on", int'(indOn), 1);
    waitTicks(SHOW + 3);
    check("R5 off, no error", int'(indOn), 0);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule